// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts processor activity for profiling. It holds one cycle counter and two event counters, each 32 bits wide. A single control word sets all of its behaviour: the global run bit, the reset actions for the counters, the slow cycle-count mode, the per-counter interrupt enables, the overflow flags and the two 8-bit event selectors. Software reaches the control word and the three counters through a small register port with an address, a write strobe with write data, and a read strobe with read data.

Event sources arrive as a vector of single-cycle pulses indexed by event code. Each event counter picks one bit of that vector through its selector. When a counter wraps from all ones to zero it sets its overflow flag. The interrupt output stays high while any flag is set whose interrupt enable is also set. Software writes back the control value it has just read to clear every pending flag.

The cycle counter is paced by a small prescaler state machine. It has three states. PS_HALT is used while the run bit is clear and gives no ticks. PS_FULL is used when running in normal mode and ticks every clock. PS_DIV is used when running in slow mode and ticks once every 64 clocks. The transitions follow the next value of the run and slow bits. Any state goes to PS_HALT when the run bit becomes clear. Any state goes to PS_FULL when running with the slow bit clear. Any state goes to PS_DIV when running with the slow bit set. On entry to PS_DIV the divide count restarts at zero.

Top module: `perf_monitor`

## Requirements
- R1: Control bit 0 is the run bit. While it is clear, none of the three counters advances.
- R2: Writing a control word with bit 1 set zeroes both event counters. Writing one with bit 2 set zeroes the cycle counter and restarts the slow-mode divide count. Bits 1 and 2 always read back as 0.
- R3: Control bit 3 selects slow mode. In slow mode the cycle counter advances on the 64th clock after the mode is entered and on every 64th clock after that. With bit 3 clear it advances on every clock while running.
- R4: Control bits 12-19 select the event for event counter 0, and bits 20-27 select it for counter 1. A code from 0x00 to 0x16 counts pulses on that bit of `event_i`. Any other code, including the unused code 0xFF, counts nothing.
- R5: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its overflow flag. The flags are control bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R6: Writing 1 to a flag position clears that flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R7: The interrupt enables are control bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter. `irq_o` is high exactly while some flag and its enable are both set.
- R8: Control bits 7, 11 and 28-31 ignore written values and read back as 0.
- R9: Register addresses are 0 for the control word, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. A write loads the addressed counter, and this load wins over an increment in the same cycle. `reg_rdata` takes the addressed value on the clock edge where `reg_rd` is high and holds it otherwise.
- R10: After reset, all counters, the control word, `reg_rdata` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| event_i | input | NUM_EVENTS (23) | Event pulses, one bit per event code |
| irq_o | output | 1 | Level interrupt on enabled overflow |

## Verification
Faults in the counters, the flags and the prescaler state appear at the ports in two ways. A bad counter value or a lost or extra flag shows in `reg_rdata` one clock after the next read of that register. A flag or enable mismatch shows on `irq_o` in the first cycle after the faulty update. A prescaler stuck in the wrong state, or a divide count that is off by one, only becomes visible after a full 64-clock period. For that reason the slow-mode run covers several periods before the cycle counter is read. The bench model follows every edge and compares the interrupt and the read data on every cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int CNT_W      = 32;
    localparam int SEL_W      = 8;
    localparam int NUM_EVENTS = 23;
    localparam int DIV_BITS   = 6;
    localparam int REG_AW     = 2;
    localparam int NUM_CH     = 3;
    localparam int EIDX_W     = $clog2(NUM_EVENTS);
    localparam int EV_PAD     = 1 << EIDX_W;

    // control word bit positions (software decodes these)
    localparam int B_RUN   = 0;
    localparam int B_EVCLR = 1;
    localparam int B_CYCLR = 2;
    localparam int B_SLOW  = 3;
    localparam int B_IE    = 4;   // 3 bits: ev0, ev1, cyc
    localparam int B_OVF   = 8;   // 3 bits: ev0, ev1, cyc
    localparam int B_SEL0  = 12;
    localparam int B_SEL1  = 20;

    // channel indices match the order of the enable and flag fields
    localparam int CH_EV0 = 0;
    localparam int CH_EV1 = 1;
    localparam int CH_CYC = 2;

    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_CYC  = 2'd1;
    localparam logic [REG_AW-1:0] A_EV0  = 2'd2;
    localparam logic [REG_AW-1:0] A_EV1  = 2'd3;

    typedef enum logic [1:0] {
        PS_HALT = 2'd0,
        PS_FULL = 2'd1,
        PS_DIV  = 2'd2
    } ps_state_e;

    function automatic logic [REG_AW-1:0] ch_addr(input int ch);
        case (ch)
            CH_EV0:  return A_EV0;
            CH_EV1:  return A_EV1;
            default: return A_CYC;
        endcase
    endfunction
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
    import pmu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [31:0]                 wdata,
    input  logic [NUM_CH-1:0]           wrap,
    output logic                        run_q,
    output logic                        run_d,
    output logic                        slow_q,
    output logic                        slow_d,
    output logic [NUM_CH-1:0]           ie_q,
    output logic [NUM_CH-1:0]           ovf_q,
    output logic [1:0][SEL_W-1:0]       sel_q,
    output logic                        evt_clr,
    output logic                        cyc_clr,
    output logic [31:0]                 rd_val
);
    logic [NUM_CH-1:0] ovf_d;
    logic [NUM_CH-1:0] w1c;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[7], wdata[11], wdata[31:28]};

    always_comb begin
        run_d   = wr ? wdata[B_RUN]  : run_q;
        slow_d  = wr ? wdata[B_SLOW] : slow_q;
        evt_clr = wr & wdata[B_EVCLR];
        cyc_clr = wr & wdata[B_CYCLR];
        w1c     = wr ? wdata[B_OVF +: NUM_CH] : '0;
        ovf_d   = (ovf_q & ~w1c) | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            slow_q <= 1'b0;
            ie_q   <= '0;
            ovf_q  <= '0;
            sel_q  <= '0;
        end else begin
            run_q  <= run_d;
            slow_q <= slow_d;
            ovf_q  <= ovf_d;
            if (wr) begin
                ie_q     <= wdata[B_IE +: NUM_CH];
                sel_q[0] <= wdata[B_SEL0 +: SEL_W];
                sel_q[1] <= wdata[B_SEL1 +: SEL_W];
            end
        end
    end

    always_comb begin
        rd_val                    = '0;
        rd_val[B_RUN]             = run_q;
        rd_val[B_SLOW]            = slow_q;
        rd_val[B_IE +: NUM_CH]    = ie_q;
        rd_val[B_OVF +: NUM_CH]   = ovf_q;
        rd_val[B_SEL0 +: SEL_W]   = sel_q[0];
        rd_val[B_SEL1 +: SEL_W]   = sel_q[1];
    end
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_d,
    input  logic slow_d,
    input  logic cyc_clr,
    output logic tick
);
    ps_state_e           state_q;
    ps_state_e           state_d;
    logic [DIV_BITS-1:0] div_q;

    // next state follows the control bits being loaded this edge
    always_comb begin
        if (!run_d)      state_d = PS_HALT;
        else if (slow_d) state_d = PS_DIV;
        else             state_d = PS_FULL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                div_q <= '0;
        else if (state_d != PS_DIV || cyc_clr)     div_q <= '0;
        else if (state_q == PS_DIV)                div_q <= div_q + 1'b1;
        else                                       div_q <= '0;
    end

    always_comb begin
        unique case (state_q)
            PS_HALT: tick = 1'b0;
            PS_FULL: tick = 1'b1;
            PS_DIV:  tick = (div_q == '1);
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);
    assign wrap = inc & ~ld & ~clr & (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (ld)  cnt_q <= ld_val;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pmu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    input  logic                  reg_rd,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_EVENTS-1:0] event_i,
    output logic                  irq_o
);
    logic                        run_q, run_d, slow_q, slow_d;
    logic [NUM_CH-1:0]           ie_q, ovf_q, wrap, inc;
    logic [1:0][SEL_W-1:0]       sel_q;
    logic                        evt_clr, cyc_clr, tick, ctrl_wr;
    logic [31:0]                 ctrl_val;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt;
    logic [EV_PAD-1:0]           ev_pad;
    logic                        unused_slow;

    assign ctrl_wr     = reg_wr && (reg_addr == A_CTRL);
    assign ev_pad      = EV_PAD'(event_i);
    assign unused_slow = slow_q;

    pmu_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .wdata   (reg_wdata),
        .wrap    (wrap),
        .run_q   (run_q),
        .run_d   (run_d),
        .slow_q  (slow_q),
        .slow_d  (slow_d),
        .ie_q    (ie_q),
        .ovf_q   (ovf_q),
        .sel_q   (sel_q),
        .evt_clr (evt_clr),
        .cyc_clr (cyc_clr),
        .rd_val  (ctrl_val)
    );

    pmu_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_d   (run_d),
        .slow_d  (slow_d),
        .cyc_clr (cyc_clr),
        .tick    (tick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_sel
        always_comb begin
            inc[g] = 1'b0;
            if (run_q && (sel_q[g] < SEL_W'(NUM_EVENTS)))
                inc[g] = ev_pad[sel_q[g][EIDX_W-1:0]];
        end
    end
    assign inc[CH_CYC] = run_q & tick;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        logic ld_c, clr_c;
        assign ld_c  = reg_wr && (reg_addr == ch_addr(c));
        assign clr_c = (c == CH_CYC) ? cyc_clr : evt_clr;
        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_c),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .clr    (clr_c),
            .inc    (inc[c]),
            .cnt_q  (cnt[c]),
            .wrap   (wrap[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) begin
            unique case (reg_addr)
                A_CTRL:  reg_rdata <= ctrl_val;
                A_CYC:   reg_rdata <= 32'(cnt[CH_CYC]);
                A_EV0:   reg_rdata <= 32'(cnt[CH_EV0]);
                A_EV1:   reg_rdata <= 32'(cnt[CH_EV1]);
                default: reg_rdata <= '0;
            endcase
        end
    end

    assign irq_o = |(ovf_q & ie_q);
endmodule

// File: rtl/perf_monitor_chk.sv
module perf_monitor_chk
    import pmu_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ctl_run,
    input logic                         reg_wr,
    input logic [REG_AW-1:0]            reg_addr,
    input logic [31:0]                  reg_wdata,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0]            wrap,
    input logic [NUM_CH-1:0]            ovf
);
    // R1
    halt_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !reg_wr) |=> $stable(cnt));

    // R2
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[B_EVCLR])
        |=> (cnt[CH_EV0] == '0 && cnt[CH_EV1] == '0));

    // R9
    cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CYC) |=> (cnt[CH_CYC] == $past(reg_wdata[CNT_W-1:0])));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_flag
        // R5
        flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf[k]) |-> $past(wrap[k]));
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[k] |=> ovf[k]);
    end
endmodule

bind perf_monitor perf_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_run   (run_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt),
    .wrap      (wrap),
    .ovf       (ovf_q)
);

// File: tb/test_perf_monitor.sv
module test_perf_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [22:0] ev = '0;
    logic        irq;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R10";

    // reference model state
    bit        m_en, m_slow;
    bit [2:0]  m_ie, m_ovf;
    bit [7:0]  m_sel0, m_sel1;
    bit [31:0] m_cyc, m_ev0, m_ev1, m_rd;
    int        m_div;

    always #10 clk = ~clk;

    perf_monitor i_perf_monitor (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rd(rd), .reg_rdata(rdata),
        .event_i(ev), .irq_o(irq)
    );

    function automatic bit hit(input bit [7:0] s);
        return (s < 8'd23) ? ev[s[4:0]] : 1'b0;
    endfunction

    function automatic bit [31:0] m_ctrl();
        bit [31:0] v = '0;
        v[0] = m_en; v[3] = m_slow; v[6:4] = m_ie; v[10:8] = m_ovf;
        v[19:12] = m_sel0; v[27:20] = m_sel1;
        return v;
    endfunction

    task automatic model_step();
        bit       old_slow_act = m_en && m_slow;
        bit       tk  = m_en && (!m_slow || m_div == 63);
        bit       i0  = m_en && hit(m_sel0);
        bit       i1  = m_en && hit(m_sel1);
        bit       cw  = wr && addr == 2'd0;
        bit       er  = cw && wdata[1];
        bit       cr  = cw && wdata[2];
        bit [2:0] wv  = '0;
        if (rd) begin
            case (addr)
                2'd0: m_rd = m_ctrl();
                2'd1: m_rd = m_cyc;
                2'd2: m_rd = m_ev0;
                default: m_rd = m_ev1;
            endcase
        end
        if (wr && addr == 2'd2) m_ev0 = wdata;
        else if (er) m_ev0 = 0;
        else if (i0) begin wv[0] = (m_ev0 == 32'hFFFF_FFFF); m_ev0 = m_ev0 + 1; end
        if (wr && addr == 2'd3) m_ev1 = wdata;
        else if (er) m_ev1 = 0;
        else if (i1) begin wv[1] = (m_ev1 == 32'hFFFF_FFFF); m_ev1 = m_ev1 + 1; end
        if (wr && addr == 2'd1) m_cyc = wdata;
        else if (cr) m_cyc = 0;
        else if (tk) begin wv[2] = (m_cyc == 32'hFFFF_FFFF); m_cyc = m_cyc + 1; end
        m_ovf = (m_ovf & ~(cw ? wdata[10:8] : 3'b000)) | wv;
        if (cw) begin
            m_en = wdata[0]; m_slow = wdata[3]; m_ie = wdata[6:4];
            m_sel0 = wdata[19:12]; m_sel1 = wdata[27:20];
        end
        if (!(m_en && m_slow) || cr) m_div = 0;
        else if (old_slow_act)       m_div = (m_div + 1) % 64;
        else                         m_div = 0;
    endtask

    task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({cur_req, " irq"}, 32'(irq), 32'(|(m_ovf & m_ie)));
        check({cur_req, " rdata"}, rdata, m_rd);
    endtask

    task automatic wr_reg(input bit [1:0] a, input bit [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cycle();
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input bit [1:0] a, input bit [31:0] exp);
        addr = a; rd = 1'b1;
        cycle();
        rd = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic pulse(input int bitn);
        ev = '0; ev[bitn] = 1'b1;
        cycle();
        ev = '0;
        cycle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-R actual=running expected=done");
        finish_run();
    end

    initial begin
        m_en = 0; m_slow = 0; m_ie = 0; m_ovf = 0; m_sel0 = 0; m_sel1 = 0;
        m_cyc = 0; m_ev0 = 0; m_ev1 = 0; m_rd = 0; m_div = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        cur_req = "R10";
        check("R10 irq", 32'(irq), 0);
        check("R10 rdata", rdata, 0);
        for (int a = 0; a < 4; a++) rd_chk("R10 reg", 2'(a), 0);

        // R4 counting selected events
        cur_req = "R4";
        wr_reg(2'd0, 32'h0160_5001);
        for (int i = 0; i < 10; i++) pulse(5);
        for (int i = 0; i < 3; i++) pulse(22);
        pulse(7);
        wr_reg(2'd0, 32'h0160_5000);
        rd_chk("R4 ev0 code 0x05", 2'd2, 10);
        rd_chk("R4 ev1 code 0x16", 2'd3, 3);

        // R1 halted: events ignored
        cur_req = "R1";
        for (int i = 0; i < 5; i++) pulse(5);
        rd_chk("R1 ev0 halted", 2'd2, 10);

        // R4 unused and out-of-range codes count nothing
        cur_req = "R4";
        wr_reg(2'd0, 32'h020F_F001);
        ev = '1;
        repeat (8) cycle();
        ev = '0;
        wr_reg(2'd0, 32'h0);
        rd_chk("R4 ev0 code 0xFF", 2'd2, 10);
        rd_chk("R4 ev1 code 0x20", 2'd3, 3);

        // R2 reset bits
        cur_req = "R2";
        wr_reg(2'd0, 32'h2);
        rd_chk("R2 ev0 cleared", 2'd2, 0);
        rd_chk("R2 ev1 cleared", 2'd3, 0);
        wr_reg(2'd0, 32'h4);
        rd_chk("R2 cyc cleared", 2'd1, 0);
        rd_chk("R2 ctrl bits 1,2 read 0", 2'd0, 0);

        // R8 reserved bits
        cur_req = "R8";
        wr_reg(2'd0, 32'hF000_0880);
        rd_chk("R8 reserved read 0", 2'd0, 0);

        // R5/R7 overflow of event counter 0 with interrupt
        cur_req = "R5";
        wr_reg(2'd2, 32'hFFFF_FFFE);
        wr_reg(2'd0, 32'h0000_1011);
        pulse(1);
        check("R5 no flag before wrap", 32'(irq), 0);
        pulse(1);
        check("R7 irq on enabled flag", 32'(irq), 1);
        rd_chk("R5 flag bit 8 set", 2'd0, 32'h0000_1111);
        rd_chk("R5 ev0 wrapped", 2'd2, 0);

        // R6 write-back clears
        cur_req = "R6";
        wr_reg(2'd0, 32'h0000_1111);
        check("R6 irq after clear", 32'(irq), 0);
        rd_chk("R6 flag cleared", 2'd0, 32'h0000_1011);

        // R7 masked flag
        cur_req = "R7";
        wr_reg(2'd3, 32'hFFFF_FFFF);
        wr_reg(2'd0, 32'h0020_1011);
        pulse(2);
        check("R7 masked flag no irq", 32'(irq), 0);
        rd_chk("R7 flag bit 9 set", 2'd0, 32'h0020_1211);
        wr_reg(2'd0, 32'h0020_1031);
        check("R7 enable raises irq", 32'(irq), 1);
        wr_reg(2'd0, 32'h0020_1231);
        check("R7 cleared irq", 32'(irq), 0);

        // R6 set wins over clear in same cycle
        cur_req = "R6";
        wr_reg(2'd2, 32'hFFFF_FFFF);
        ev = '0; ev[1] = 1'b1;
        wr_reg(2'd0, 32'h0020_1131);
        ev = '0;
        cycle();
        check("R6 set wins irq", 32'(irq), 1);
        rd_chk("R6 set wins flag", 2'd0, 32'h0020_1131);

        // R1/R3 full-rate cycle counting
        cur_req = "R3";
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'h1);
        repeat (20) cycle();
        wr_reg(2'd0, 32'h0);
        rd_chk("R3 full rate count", 2'd1, 21);
        cur_req = "R1";
        repeat (10) cycle();
        rd_chk("R1 cycle halted", 2'd1, 21);

        // R3 slow mode
        cur_req = "R3";
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'h9);
        repeat (200) cycle();
        wr_reg(2'd0, 32'h8);
        rd_chk("R3 slow count", 2'd1, 3);

        // R9 load wins over increment, read data holds
        cur_req = "R9";
        wr_reg(2'd0, 32'h0000_1001);
        ev = '0; ev[1] = 1'b1;
        wr_reg(2'd2, 32'h0000_1234);
        ev = '0;
        wr_reg(2'd0, 32'h0);
        rd_chk("R9 load wins", 2'd2, 32'h0000_1234);
        addr = 2'd1;
        repeat (3) cycle();
        check("R9 rdata holds", rdata, 32'h0000_1234);

        finish_run();
    end
endmodule